// File: doc/BRIEF.md
# Measurement Period Counter with Latch-Clear-Fraction Sequencer

This block measures the length of each period of a slow measurement waveform in cycles of a fast local clock. The measurement input is first brought into the clock domain through a synchronizer chain. Each accepted rising edge starts a short three-step sequence, one clock cycle per step. The first step latches the running counter into an output register. The second step clears the counter. The third step captures an externally supplied sub-cycle fraction value. The counter stands still during the latch and clear steps, so every latched raw count is two cycles short of the true period. The block therefore also reports a compensated period, which is the raw count plus two.

Once the sequence has run, the block waits until the synchronized measurement level is low again. It then adds the compensated period into a running phase total. A rising edge that arrives while the sequence is still running is dropped, and a saturating counter records how many edges were lost. The period counter stops at its largest value instead of wrapping, and a flag marks any period whose count was cut short in this way. Downstream logic uses the strobes to pick up the period, the fraction and the running total in the cycles where each one changes.

Top module: `meas_period_timer`

## Requirements
- R1: The measurement input passes through a two-stage synchronizer. When `meas_in` is first sampled high at clock edge n, after at least two low samples, `save_stb` is high in the cycle that follows edge n+3.
- R2: Each accepted rising edge gives exactly one `save_stb`, one `clr_stb` and one `frac_stb` pulse, each one cycle wide, in that order on consecutive cycles. No two of them are ever high together.
- R3: `count_q` holds P-2, where P is the number of clock cycles between the previous accepted rising edge and the current one. It changes only in the cycle where `save_stb` is high.
- R4: `period_q` equals the latched raw count plus 2 (`count_q` + 2). It is updated in the same cycle as `count_q`.
- R5: `frac_q` takes the value of `frac_in` from the clock edge that ends the clear step, so it is valid while `frac_stb` is high. It holds that value in every other cycle.
- R6: After each accepted rising edge, the first cycle in which the synchronized measurement level is low adds `period_q` into `acc_q`, and `acc_stb` pulses for one cycle after that edge. `acc_q` changes at no other time.
- R7: The period counter saturates at 2^CNT_W-1. `ovf_q` is set with the latched count when the period needed more counts than that. A period of exactly 2^CNT_W+1 cycles gives `count_q` = 2^CNT_W-1 with `ovf_q` = 0. A period of 2^CNT_W+2 cycles gives the same count with `ovf_q` = 1.
- R8: A rising edge recognized while the sequence is still running (latch, clear or fraction step) is ignored. It produces no strobe, and the next period is still measured from the accepted edge. `miss_q` then increases by one and saturates at its maximum.
- R9: While `rst` is high, every output register and strobe is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_in | input | 1 | Asynchronous measurement waveform |
| frac_in | input | FRAC_W | Sub-cycle fraction value, sampled at the fraction step |
| count_q | output | CNT_W | Raw latched period count (true period minus 2) |
| period_q | output | CNT_W+1 | Compensated period count (raw plus 2) |
| ovf_q | output | 1 | Latched count was cut short by saturation |
| frac_q | output | FRAC_W | Captured fraction value |
| acc_q | output | ACC_W | Running total of compensated periods |
| miss_q | output | MISS_W | Saturating count of rising edges that were ignored |
| save_stb | output | 1 | Count and period were latched this cycle |
| clr_stb | output | 1 | Counter was cleared this cycle |
| frac_stb | output | 1 | Fraction was captured this cycle |
| acc_stb | output | 1 | Running total was updated this cycle |

## Verification
Two pairs of events can fall in the same cycle. The first pair is counter saturation and the latch step. The bench uses an 8-bit counter and drives periods of 257 and 258 cycles. In the first case the count reaches its ceiling exactly at the latch. In the second case the counter tries to go one past the ceiling. The bench expects the same raw count in both cases, with the overflow flag clear for the first and set for the second. The second pair is a narrow high-low-high glitch on the measurement input, placed so that the second rising edge is recognized during the clear step. The bench judges this case from the ports: the missed-edge count must rise by one, no extra strobes may appear, and the next latched count must match a period measured from the first edge.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  // Cycles in which the counter is frozen by the latch and clear steps.
  localparam int PERIOD_COMP = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SAVE  = 3'd1,
    ST_CLEAR = 3'd2,
    ST_FRAC  = 3'd3,
    ST_WAIT  = 3'd4
  } seq_state_t;

endpackage

// File: rtl/mpt_sync.sv
module mpt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev_q;

endmodule

// File: rtl/mpt_counter.sv
module mpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             sat
);

  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      sat <= 1'b0;
    end else if (!hold) begin
      if (cnt == MAX_V) sat <= 1'b1;
      else              cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mpt_seq.sv
module mpt_seq
  import mpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic level,
  output logic save_p,
  output logic clr_p,
  output logic frac_p,
  output logic acc_p,
  output logic miss_p
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (rise) state_d = ST_SAVE;
      ST_SAVE:  state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_FRAC;
      ST_FRAC:  state_d = ST_WAIT;
      ST_WAIT:  if (!level) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign save_p = (state_q == ST_SAVE);
  assign clr_p  = (state_q == ST_CLEAR);
  assign frac_p = (state_q == ST_FRAC);
  assign acc_p  = (state_q == ST_WAIT) && !level;
  assign miss_p = rise && (state_q != ST_IDLE);

endmodule

// File: rtl/meas_period_timer.sv
module meas_period_timer
  import mpt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int FRAC_W      = 3,
  parameter int ACC_W       = 48,
  parameter int MISS_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              meas_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W:0]    period_q,
  output logic              ovf_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [ACC_W-1:0]  acc_q,
  output logic [MISS_W-1:0] miss_q,
  output logic              save_stb,
  output logic              clr_stb,
  output logic              frac_stb,
  output logic              acc_stb
);

  localparam int PER_W = CNT_W + 1;
  localparam logic [PER_W-1:0]  COMP_V   = PER_W'(PERIOD_COMP);
  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  logic             m_level, m_rise;
  logic             save_p, clr_p, frac_p, acc_p, miss_p;
  logic [CNT_W-1:0] cnt;
  logic             sat;

  mpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (meas_in),
    .level    (m_level),
    .rise     (m_rise)
  );

  mpt_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .rise   (m_rise),
    .level  (m_level),
    .save_p (save_p),
    .clr_p  (clr_p),
    .frac_p (frac_p),
    .acc_p  (acc_p),
    .miss_p (miss_p)
  );

  mpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .hold  (save_p),
    .clear (clr_p),
    .cnt   (cnt),
    .sat   (sat)
  );

  // Latch step: raw count, compensated period and saturation flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      period_q <= '0;
      ovf_q    <= 1'b0;
    end else if (save_p) begin
      count_q  <= cnt;
      period_q <= {1'b0, cnt} + COMP_V;
      ovf_q    <= sat;
    end
  end

  // Fraction step.
  always_ff @(posedge clk) begin
    if (rst)         frac_q <= '0;
    else if (frac_p) frac_q <= frac_in;
  end

  // Running phase total.
  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (acc_p) acc_q <= acc_q + ACC_W'(period_q);
  end

  // Dropped-edge tally.
  always_ff @(posedge clk) begin
    if (rst)                          miss_q <= '0;
    else if (miss_p && miss_q != MISS_MAX) miss_q <= miss_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      save_stb <= 1'b0;
      clr_stb  <= 1'b0;
      frac_stb <= 1'b0;
      acc_stb  <= 1'b0;
    end else begin
      save_stb <= save_p;
      clr_stb  <= clr_p;
      frac_stb <= frac_p;
      acc_stb  <= acc_p;
    end
  end

endmodule

// File: rtl/mpt_checker.sv
module mpt_checker #(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 3,
  parameter int ACC_W  = 48,
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  count_q,
  input logic              ovf_q,
  input logic [FRAC_W-1:0] frac_q,
  input logic [ACC_W-1:0]  acc_q,
  input logic [MISS_W-1:0] miss_q,
  input logic              save_stb,
  input logic              clr_stb,
  input logic              frac_stb,
  input logic              acc_stb
);

  // R2
  save_then_clear_chk: assert property (@(posedge clk) disable iff (rst)
    save_stb |=> clr_stb);

  // R2
  clear_then_frac_chk: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> frac_stb);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_stb, clr_stb, frac_stb}));

  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !save_stb |-> $stable(count_q));

  // R5
  frac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frac_stb |-> $stable(frac_q));

  // R6
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_stb |-> $stable(acc_q));

  // R7
  ovf_at_max_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (count_q == {CNT_W{1'b1}}));

  // R8
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_q != $past(miss_q)) |-> (miss_q == $past(miss_q) + 1'b1));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_q == '0 && miss_q == '0 && count_q == '0));

endmodule

bind meas_period_timer mpt_checker #(
  .CNT_W  (CNT_W),
  .FRAC_W (FRAC_W),
  .ACC_W  (ACC_W),
  .MISS_W (MISS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .count_q  (count_q),
  .ovf_q    (ovf_q),
  .frac_q   (frac_q),
  .acc_q    (acc_q),
  .miss_q   (miss_q),
  .save_stb (save_stb),
  .clr_stb  (clr_stb),
  .frac_stb (frac_stb),
  .acc_stb  (acc_stb)
);

// File: tb/meas_period_timer_tb.sv
module meas_period_timer_tb;

  localparam int CW = 8;
  localparam int FW = 3;
  localparam int AW = 32;
  localparam int MW = 8;
  localparam int NV = 10;
  localparam int NOBS = 16;
  localparam int CMAX = (1 << CW) - 1;

  typedef struct packed {
    logic [15:0] hi;
    logic [15:0] lo;
    logic [2:0]  fr;
  } vec_t;

  // high cycles, low cycles, fraction; period = hi + lo
  localparam vec_t VECS [NV] = '{
    '{16'd5,   16'd5,   3'd3},
    '{16'd4,   16'd8,   3'd0},
    '{16'd10,  16'd6,   3'd7},
    '{16'd3,   16'd9,   3'd1},
    '{16'd20,  16'd30,  3'd5},
    '{16'd6,   16'd6,   3'd2},
    '{16'd100, 16'd157, 3'd4},
    '{16'd100, 16'd158, 3'd6},
    '{16'd8,   16'd9,   3'd0},
    '{16'd7,   16'd7,   3'd7}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          meas_in;
  logic [FW-1:0] frac_in;
  logic [CW-1:0] count_q;
  logic [CW:0]   period_q;
  logic          ovf_q;
  logic [FW-1:0] frac_q;
  logic [AW-1:0] acc_q;
  logic [MW-1:0] miss_q;
  logic          save_stb, clr_stb, frac_stb, acc_stb;

  always #10 clk = ~clk;

  meas_period_timer #(
    .CNT_W(CW), .FRAC_W(FW), .ACC_W(AW), .MISS_W(MW), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst), .meas_in(meas_in), .frac_in(frac_in),
    .count_q(count_q), .period_q(period_q), .ovf_q(ovf_q), .frac_q(frac_q),
    .acc_q(acc_q), .miss_q(miss_q), .save_stb(save_stb), .clr_stb(clr_stb),
    .frac_stb(frac_stb), .acc_stb(acc_stb)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor: records strobed values, written only here.
  int obs_cnt [NOBS];
  int obs_per [NOBS];
  int obs_ovf [NOBS];
  int obs_scyc[NOBS];
  int obs_frac[NOBS];
  int obs_acc [NOBS];
  int n_save = 0, n_frac = 0, n_acc = 0, seq_err = 0;
  logic prev_save = 1'b0, prev_clr = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (save_stb && n_save < NOBS) begin
        obs_cnt[n_save]  = int'(count_q);
        obs_per[n_save]  = int'(period_q);
        obs_ovf[n_save]  = int'(ovf_q);
        obs_scyc[n_save] = cyc;
      end
      if (save_stb) n_save++;
      if (frac_stb && n_frac < NOBS) obs_frac[n_frac] = int'(frac_q);
      if (frac_stb) n_frac++;
      if (acc_stb && n_acc < NOBS) obs_acc[n_acc] = int'(acc_q);
      if (acc_stb) n_acc++;
      if (clr_stb && !prev_save) seq_err++;
      if (frac_stb && !prev_clr) seq_err++;
      if (save_stb && (clr_stb || frac_stb)) seq_err++;
      prev_save = save_stb;
      prev_clr  = clr_stb;
    end
  end

  int n_chk = 0, n_fail = 0;
  int rise_cyc[NOBS];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_raw(input int p);
    return (p - 2 > CMAX) ? CMAX : p - 2;
  endfunction

  task automatic drive(input int hi, input int lo);
    meas_in = 1'b1;
    repeat (hi) @(negedge clk);
    meas_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int sum;
    rst = 1'b1;
    meas_in = 1'b0;
    frac_in = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 count_q", int'(count_q), 0);
    chk("R9 period_q", int'(period_q), 0);
    chk("R9 acc_q", int'(acc_q), 0);
    chk("R9 miss_q", int'(miss_q), 0);
    chk("R9 strobes", int'({save_stb, clr_stb, frac_stb, acc_stb, ovf_q}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // Table walk: one period per vector.
    for (int i = 0; i < NV; i++) begin
      rise_cyc[i] = cyc;
      frac_in = VECS[i].fr;
      drive(int'(VECS[i].hi), int'(VECS[i].lo));
    end

    // R8: glitch puts a second rising edge into the clear step. Period 20.
    rise_cyc[NV] = cyc;
    frac_in = 3'd2;
    meas_in = 1'b1; @(negedge clk);
    meas_in = 1'b0; @(negedge clk);
    drive(8, 10);

    // Closing period so the glitch period gets latched.
    rise_cyc[NV+1] = cyc;
    frac_in = 3'd5;
    drive(6, 6);
    repeat (20) @(negedge clk);

    // R2 / R8: strobe counts and order
    chk("R2 strobe order errors", seq_err, 0);
    chk("R8 save strobes", n_save, NV + 2);
    chk("R8 frac strobes", n_frac, NV + 2);
    chk("R6 acc strobes", n_acc, NV + 2);
    chk("R8 miss_q", int'(miss_q), 1);

    // R1: latency from first high sample to save strobe
    for (int i = 0; i < NV + 2; i++)
      chk("R1 save latency", obs_scyc[i], rise_cyc[i] + 4);

    // R3 R4 R7: latched counts
    for (int i = 1; i <= NV; i++) begin
      int p;
      p = int'(VECS[i-1].hi) + int'(VECS[i-1].lo);
      chk("R3 count_q", obs_cnt[i], exp_raw(p));
      chk("R4 period_q", obs_per[i], exp_raw(p) + 2);
      chk("R7 ovf_q", obs_ovf[i], (p - 2 > CMAX) ? 1 : 0);
    end
    chk("R8 count after ignored edge", obs_cnt[NV+1], 18);
    chk("R8 ovf after ignored edge", obs_ovf[NV+1], 0);

    // R5: fraction capture
    for (int i = 0; i < NV; i++)
      chk("R5 frac_q", obs_frac[i], int'(VECS[i].fr));
    chk("R5 frac_q glitch period", obs_frac[NV], 2);
    chk("R5 frac_q last", obs_frac[NV+1], 5);

    // R6: running total, first latch taken as observed baseline
    sum = obs_per[0];
    chk("R6 acc_q", obs_acc[0], sum);
    for (int j = 1; j <= NV; j++) begin
      sum += exp_raw(int'(VECS[j-1].hi) + int'(VECS[j-1].lo)) + 2;
      chk("R6 acc_q", obs_acc[j], sum);
    end
    sum += 20;
    chk("R6 acc_q glitch period", obs_acc[NV+1], sum);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule